// File: doc/BRIEF.md
# Boot-Gated Core Reset Sequencer

This block turns an active-low board reset into the core reset of a chip. Pulling the board reset low forces the core reset on at once, even when no clock is running. Releasing it starts a release sequence that is synchronized to the system clock. While the core is held in reset, the block asks the pad ring to float every bus and I/O driver and to pull the Port0 pins high.

The way the core reset is released depends on a boot-select level, which is captured while reset is still held. When the core boots from on-chip memory, the core stays in reset until the nonvolatile memory reports that its own initialization is complete. That initialization is timed by a separate, dedicated clock. When the core boots from external memory, the core leaves reset after a short, fixed number of system clocks.

While the on-chip memory is still initializing, reads from it return fixed placeholder words. The word is 16'hFFFF early in the initialization and 16'h009B later on. Once initialization is done, the real array data is passed through.

Top module: `boot_reset_ctrl`

## Requirements
- R1: A low level on `ext_rst_n` drives `core_rst_n` low with no `clk` edge needed, both from the running state and during a release sequence.
- R2: `bus_hiz` and `port0_pullup` are 1 whenever `core_rst_n` is 0, and both are 0 once `core_rst_n` is 1.
- R3: `boot_int_sel` (1 = boot from on-chip memory, 0 = boot from external memory) is sampled on every `clk` edge up to and including the third edge after `ext_rst_n` rises. A change on it from the fourth edge onward has no effect on the release path.
- R4: With internal boot selected, `core_rst_n` stays 0 while `mem_init_done` is 0. It rises on the first `clk` edge at which `mem_init_done` is already seen high.
- R5: `mem_init_done` rises after INIT_TICKS (default 64) `init_clk` rising edges following the release of `ext_rst_n`, plus a two-stage `clk` synchronizer. It then stays 1 until the next reset.
- R6: With external boot selected, `core_rst_n` rises on `clk` rising edge number FILTER_CLKS + EXTRA_CLKS + 3 after `ext_rst_n` rises (edge 12 with defaults 4 and 5). EXTRA_CLKS is clamped to the range 3 to 8.
- R7: While `mem_init_done` is 0, `mem_rdata` reads 16'hFFFF until PHASE_TICKS (default 8) `init_clk` edges have elapsed, and 16'h009B after that. Once `mem_init_done` is 1, `mem_rdata` equals `arr_rdata`.
- R8: Asserting `ext_rst_n` again at any point of a release sequence aborts that sequence, including the memory initialization timer. The next release starts the full sequence again from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| init_clk | input | 1 | Dedicated clock of the memory initialization timer |
| ext_rst_n | input | 1 | Active-low board reset, asynchronous |
| boot_int_sel | input | 1 | Boot source level: 1 = on-chip memory, 0 = external memory |
| arr_rdata | input | 16 | Read data from the on-chip memory array |
| core_rst_n | output | 1 | Active-low core reset |
| bus_hiz | output | 1 | Float all bus and I/O drivers |
| port0_pullup | output | 1 | Enable the Port0 pull-ups |
| mem_init_done | output | 1 | On-chip memory initialization complete (clk domain) |
| mem_rdata | output | 16 | Memory read data, or a placeholder word during initialization |

## Verification
A delay counter that is off by even one shows up as a core release one `clk` edge too early or too late on the external path. The bench therefore samples the exact edge. A boot-select that is not latched, or a timer that survives a reset re-assertion, shows up within one release sequence: either as a wrong release path or as a placeholder word that is already in its late phase right after release. A failure of asynchronous assertion is visible within a fraction of a clock period, before any edge can mask it.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] PRE_EARLY_WORD = 16'hFFFF;
  localparam logic [WORD_W-1:0] PRE_LATE_WORD  = 16'h009B;

  typedef enum logic [1:0] {
    SEQ_HOLD     = 2'd0,
    SEQ_EXT_DLY  = 2'd1,
    SEQ_MEM_WAIT = 2'd2,
    SEQ_RUN      = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer, cleared asynchronously, set synchronously.
module rstseq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_init_timer.sv
`timescale 1ns/1ps
// Memory initialization timer, running from its own clock.
module rstseq_init_timer #(
  parameter int INIT_TICKS  = 64,
  parameter int PHASE_TICKS = 8
) (
  input  logic init_clk,
  input  logic arst_n,
  output logic late_o,
  output logic done_o
);
  localparam int            CW         = $clog2(INIT_TICKS + 1);
  localparam logic [CW-1:0] LAST_CNT   = CW'(INIT_TICKS - 1);
  localparam logic [CW-1:0] PHASE_CNT  = CW'(PHASE_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          late_q, late_d;
  logic          done_q, done_d;
  logic          tick_en;

  always_comb begin
    tick_en = !done_q;
    cnt_d   = cnt_q;
    if (tick_en) cnt_d = cnt_q + 1'b1;
    late_d  = late_q | (tick_en && (cnt_q == PHASE_CNT));
    done_d  = done_q | (tick_en && (cnt_q == LAST_CNT));
  end

  always_ff @(posedge init_clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      late_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (tick_en) cnt_q <= cnt_d;
      late_q <= late_d;
      done_q <= done_d;
    end
  end

  assign late_o = late_q;
  assign done_o = done_q;
endmodule

// File: rtl/rstseq_fsm.sv
`timescale 1ns/1ps
// Release sequencer in the system clock domain.
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int FILTER_CLKS = 4,
  parameter int EXTRA_CLKS  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_sel_i,
  input  logic mem_done_i,
  output logic core_rst_n_o,
  output logic boot_int_o
);
  localparam int EXTRA_EFF = (EXTRA_CLKS < 3) ? 3 : ((EXTRA_CLKS > 8) ? 8 : EXTRA_CLKS);
  localparam int TOTAL     = FILTER_CLKS + EXTRA_EFF;
  localparam int DW        = $clog2(TOTAL);
  localparam logic [DW-1:0] DLY_LAST = DW'(TOTAL - 1);

  seq_state_e    state_q, state_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          core_q, core_d;
  logic          boot_q;
  logic          boot_en;

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    unique case (state_q)
      SEQ_HOLD: begin
        dly_d   = '0;
        state_d = boot_sel_i ? SEQ_MEM_WAIT : SEQ_EXT_DLY;
      end
      SEQ_EXT_DLY: begin
        if (dly_q == DLY_LAST) state_d = SEQ_RUN;
        else                   dly_d   = dly_q + 1'b1;
      end
      SEQ_MEM_WAIT: begin
        if (mem_done_i) state_d = SEQ_RUN;
      end
      SEQ_RUN: state_d = SEQ_RUN;
      default: state_d = SEQ_HOLD;
    endcase
    core_d  = (state_d == SEQ_RUN);
    boot_en = (state_q == SEQ_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_HOLD;
      dly_q   <= '0;
      core_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
      core_q  <= core_d;
    end
  end

  // Boot level capture: keeps sampling while the sequencer holds.
  always_ff @(posedge clk) begin
    if (boot_en) boot_q <= boot_sel_i;
  end

  assign core_rst_n_o = core_q;
  assign boot_int_o   = boot_q;
endmodule

// File: rtl/boot_reset_ctrl.sv
`timescale 1ns/1ps
module boot_reset_ctrl
  import rstseq_pkg::*;
#(
  parameter int FILTER_CLKS = 4,
  parameter int EXTRA_CLKS  = 5,
  parameter int INIT_TICKS  = 64,
  parameter int PHASE_TICKS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              init_clk,
  input  logic              ext_rst_n,
  input  logic              boot_int_sel,
  input  logic [WORD_W-1:0] arr_rdata,
  output logic              core_rst_n,
  output logic              bus_hiz,
  output logic              port0_pullup,
  output logic              mem_init_done,
  output logic [WORD_W-1:0] mem_rdata
);
  logic       rst_sync_n;
  logic       tmr_late, tmr_done;
  logic [1:0] flags_sync;
  logic       late_sync;
  logic       boot_int_q;

  rstseq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .arst_n(ext_rst_n), .d(1'b1), .q(rst_sync_n)
  );

  rstseq_init_timer #(.INIT_TICKS(INIT_TICKS), .PHASE_TICKS(PHASE_TICKS)) u_timer (
    .init_clk(init_clk), .arst_n(ext_rst_n), .late_o(tmr_late), .done_o(tmr_done)
  );

  rstseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_flag_sync (
    .clk(clk), .arst_n(ext_rst_n), .d({tmr_done, tmr_late}), .q(flags_sync)
  );

  assign mem_init_done = flags_sync[1];
  assign late_sync     = flags_sync[0];

  rstseq_fsm #(.FILTER_CLKS(FILTER_CLKS), .EXTRA_CLKS(EXTRA_CLKS)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .boot_sel_i(boot_int_sel),
    .mem_done_i(mem_init_done), .core_rst_n_o(core_rst_n), .boot_int_o(boot_int_q)
  );

  assign bus_hiz      = ~core_rst_n;
  assign port0_pullup = ~core_rst_n;

  always_comb begin
    if (mem_init_done)  mem_rdata = arr_rdata;
    else if (late_sync) mem_rdata = PRE_LATE_WORD;
    else                mem_rdata = PRE_EARLY_WORD;
  end
endmodule

// File: rtl/rstseq_chk.sv
`timescale 1ns/1ps
module rstseq_chk
  import rstseq_pkg::*;
(
  input logic              clk,
  input logic              ext_rst_n,
  input logic              core_rst_n,
  input logic              boot_int_q,
  input logic              mem_init_done,
  input logic [WORD_W-1:0] mem_rdata
);
  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    mem_init_done |=> mem_init_done);

  // R4
  int_gate_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    ($rose(core_rst_n) && boot_int_q) |-> $past(mem_init_done));

  // R7
  pre_word_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !mem_init_done |-> (mem_rdata == PRE_EARLY_WORD || mem_rdata == PRE_LATE_WORD));

  // R7
  phase_order_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (!mem_init_done && mem_rdata == PRE_LATE_WORD) |=> (mem_rdata != PRE_EARLY_WORD));

  // R6
  run_hold_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    core_rst_n |=> core_rst_n);
endmodule

bind boot_reset_ctrl rstseq_chk i_rstseq_chk (
  .clk(clk), .ext_rst_n(ext_rst_n), .core_rst_n(core_rst_n),
  .boot_int_q(boot_int_q), .mem_init_done(mem_init_done), .mem_rdata(mem_rdata)
);

// File: tb/test_boot_reset_ctrl.sv
`timescale 1ns/1ps
module test_boot_reset_ctrl;
  logic        clk = 1'b0;
  logic        init_clk = 1'b0;
  logic        ext_rst_n;
  logic        boot_int_sel;
  logic [15:0] arr_rdata;
  logic        core_rst_n, bus_hiz, port0_pullup, mem_init_done;
  logic [15:0] mem_rdata;
  int n_chk = 0;
  int n_fail = 0;
  bit timed_out = 0;
  longint t_rel;

  always #2.5 clk = ~clk;
  always #10  init_clk = ~init_clk;

  boot_reset_ctrl i_boot_reset_ctrl (
    .clk(clk), .init_clk(init_clk), .ext_rst_n(ext_rst_n), .boot_int_sel(boot_int_sel),
    .arr_rdata(arr_rdata), .core_rst_n(core_rst_n), .bus_hiz(bus_hiz),
    .port0_pullup(port0_pullup), .mem_init_done(mem_init_done), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_reset(input logic sel);
    @(negedge clk);
    ext_rst_n = 1'b0;
    boot_int_sel = sel;
    #1;
    chk("R1 core_rst_n on assert", core_rst_n, 0);
    chk("R2 bus_hiz in reset", bus_hiz, 1);
    chk("R2 port0_pullup in reset", port0_pullup, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic release_rst();
    @(negedge clk);
    ext_rst_n = 1'b1;
    t_rel = $time;
  endtask

  // Counts 12 clk edges after release; R6 exact edge.
  task automatic count_ext_release(input string tag, input bit flip_sel);
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk);
      #1;
      if (flip_sel && k == 5) boot_int_sel = 1'b1;  // R3: late change ignored
      if (k == 11) chk({tag, " core_rst_n edge 11"}, core_rst_n, 0);
      if (k == 12) begin
        chk({tag, " core_rst_n edge 12"}, core_rst_n, 1);
        chk("R2 bus_hiz released", bus_hiz, 0);
        chk("R2 port0_pullup released", port0_pullup, 0);
      end
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    longint el;
    while (!mem_init_done && n < 600) begin
      @(negedge clk);
      n++;
    end
    el = $time - t_rel;
    chk({tag, " done reached"}, mem_init_done, 1);
    chk({tag, " done timing"}, (el >= 1265 && el <= 1295), 1);
    chk("R4 core held at done", core_rst_n, 0);
    @(negedge clk);
    chk("R4 core released after done", core_rst_n, 1);
  endtask

  task automatic t_reset_state();
    chk("R2 bus_hiz at start", bus_hiz, 1);
    chk("R2 port0_pullup at start", port0_pullup, 1);
    chk("R1 core_rst_n at start", core_rst_n, 0);
    chk("R5 done at start", mem_init_done, 0);
    chk("R7 rdata at start", mem_rdata, 16'hFFFF);
  endtask

  task automatic t_ext_boot();
    hold_reset(1'b0);
    release_rst();
    count_ext_release("R6 R3", 1'b1);
    repeat (20) @(negedge clk);
    chk("R3 still released after sel flip", core_rst_n, 1);
    @(negedge clk);
    #1 ext_rst_n = 1'b0;
    #1.5;
    chk("R1 async assert from run", core_rst_n, 0);
    chk("R2 bus_hiz after async assert", bus_hiz, 1);
  endtask

  task automatic t_abort_ext();
    hold_reset(1'b0);
    release_rst();
    repeat (6) @(posedge clk);
    @(negedge clk);
    ext_rst_n = 1'b0;
    #1;
    chk("R8 R1 abort mid-sequence", core_rst_n, 0);
    repeat (2) @(negedge clk);
    release_rst();
    count_ext_release("R8 restart", 1'b0);
  endtask

  task automatic t_int_boot();
    arr_rdata = 16'h1234;
    hold_reset(1'b1);
    release_rst();
    repeat (3) @(posedge init_clk);
    #14;
    chk("R7 early word", mem_rdata, 16'hFFFF);
    chk("R4 core held early", core_rst_n, 0);
    chk("R5 not done early", mem_init_done, 0);
    repeat (8) @(posedge init_clk);
    #14;
    chk("R7 late word", mem_rdata, 16'h009B);
    chk("R4 core held late", core_rst_n, 0);
    wait_done("R5");
    chk("R7 array data after done", mem_rdata, 16'h1234);
    arr_rdata = 16'hA5C3;
    #1;
    chk("R7 array data follows", mem_rdata, 16'hA5C3);
    repeat (10) @(negedge clk);
    chk("R5 done stays", mem_init_done, 1);
  endtask

  task automatic t_abort_int();
    hold_reset(1'b1);
    release_rst();
    repeat (12) @(posedge init_clk);
    #14;
    chk("R7 late word before abort", mem_rdata, 16'h009B);
    @(negedge clk);
    ext_rst_n = 1'b0;
    #1;
    chk("R8 rdata back to early on abort", mem_rdata, 16'hFFFF);
    repeat (3) @(negedge clk);
    release_rst();
    repeat (3) @(posedge init_clk);
    #14;
    chk("R8 timer restarted", mem_rdata, 16'hFFFF);
    wait_done("R8");
  endtask

  initial begin
    ext_rst_n = 1'b0;
    boot_int_sel = 1'b0;
    arr_rdata = 16'h0000;
    fork
      begin
        #1;
        t_reset_state();
        t_ext_boot();
        t_abort_ext();
        t_int_boot();
        t_abort_int();
      end
      begin
        #1ms;
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule